// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block holds a bank of programmable decode windows that steer CPU physical addresses toward on-chip targets. Software programs each window through a 32-bit register port with an enable, a 4-bit target ID, an 8-bit attribute, a power-of-two size in 64 KB units and a base address. A lookup port then takes a 36-bit physical address and reports, one cycle later, whether a window matched. It also returns that window's target ID and attribute, and the address to forward.

The lower windows may carry a remap value. On a hit in such a window the address bits above the window's offset are replaced by the remap value, so a window at one CPU address can reach a different address on the target side. Windows above the remappable count forward the address unchanged.

The register map has two layouts. The first eight windows each have a 16-byte group. Windows from eight up are packed two words apart, after a reserved 16-byte gap. When several windows match, the lowest-numbered one wins.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous reset every window is disabled, every register reads zero, `lk_out_valid` is low and a lookup misses.
- R2: The control word uses bit 0 as enable, bits 7:4 as target ID, bits 15:8 as attribute and bits 31:16 as (size/64 KB − 1). Bits 3:1 are not stored and read zero.
- R3: The base word keeps address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. Bits 15:4 read zero.
- R4: A window hits when it is enabled and address bits 35:16 equal the base bits wherever the size field holds a zero. Addresses just below and just above the window miss. The first and last byte of the window hit.
- R5: Window n below 8 has control at n×16, base at n×16+4, remap low at n×16+8 and remap high at n×16+12. Window n from 8 up has control at 0x90+(n−8)×8 and base 4 bytes above that. Offsets 0x80–0x8F are reserved: they read zero and writes to them have no effect.
- R6: On a hit in a window with index below NUM_REMAP, output bits 35:16 take the remap value (remap low bits 31:16 become address bits 31:16, remap high bits 3:0 become bits 35:32) wherever the size field holds a zero. All other output bits come from the input.
- R7: A window at or above NUM_REMAP forwards the address unchanged on a hit. Its remap offsets (windows below 8) read zero and ignore writes.
- R8: When several windows hit, the output follows the lowest-numbered one.
- R9: On a miss `lk_hit`, `lk_target` and `lk_attr` are zero and `lk_out_addr` equals the input address.
- R10: Writing zero to a window's control register disables it, and the window then never hits.
- R11: Lookup results appear one cycle after `lk_valid`, with `lk_out_valid` set. A lookup in the same cycle as a register write sees the configuration from before the write. Read data appears one cycle after `reg_rd`, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to decode |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A window matched |
| lk_target | output | 4 | Target ID of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_out_addr | output | 36 | Translated or forwarded address |

## Verification
The bench builds the decoder with 20 windows and 4 remappable windows. With these values both register layouts are present, along with the reserved gap between them. Windows 4 to 7 then have 16-byte groups but no remap, which exercises the ignored remap offsets and the pass-through path. Windows 0 and 9 are placed over the same region to test priority and disabling, and window 10 uses the high base bits with a full 4 GB size.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int AWD_ADDR_W    = 36;
  localparam int AWD_PG_BITS   = 16;
  localparam int AWD_HI_W      = AWD_ADDR_W - AWD_PG_BITS;
  localparam int AWD_EXT_W     = AWD_ADDR_W - 32;
  localparam int AWD_SZ_W      = 32 - AWD_PG_BITS;
  localparam int AWD_WIDE_WINS = 8;
  localparam int AWD_PACK_BASE = 'h90;
  localparam int AWD_HOLE_LO   = 'h80;
  localparam int AWD_HOLE_HI   = 'h8F;

  typedef struct packed {
    logic                en;
    logic [3:0]          tgt;
    logic [7:0]          attr;
    logic [AWD_SZ_W-1:0] szm;
    logic [AWD_HI_W-1:0] base;
    logic [AWD_HI_W-1:0] remap;
  } awd_win_t;

  function automatic int awd_win_off(input int n);
    if (n < AWD_WIDE_WINS) return n * 16;
    return AWD_PACK_BASE + (n - AWD_WIDE_WINS) * 8;
  endfunction
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 4,
  parameter int REG_AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [REG_AW-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output awd_win_t [NUM_WIN-1:0]     win
);
  logic [31:0] rd_vec [NUM_WIN];
  logic [31:0] rd_mux;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int  OFF     = awd_win_off(w);
    localparam bit  HAS_RMP = (w < NUM_REMAP);
    awd_win_t cfg_q;
    logic sel_c, sel_b, sel_l, sel_h;

    assign sel_c = (addr == REG_AW'(OFF));
    assign sel_b = (addr == REG_AW'(OFF + 4));
    assign sel_l = HAS_RMP && (addr == REG_AW'(OFF + 8));
    assign sel_h = HAS_RMP && (addr == REG_AW'(OFF + 12));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q <= '0;
      end else if (wr_en) begin
        if (sel_c) begin
          cfg_q.en   <= wdata[0];
          cfg_q.tgt  <= wdata[7:4];
          cfg_q.attr <= wdata[15:8];
          cfg_q.szm  <= wdata[31:16];
        end
        if (sel_b) cfg_q.base <= {wdata[AWD_EXT_W-1:0], wdata[31:16]};
        if (sel_l) cfg_q.remap[AWD_SZ_W-1:0] <= wdata[31:16];
        if (sel_h) cfg_q.remap[AWD_HI_W-1:AWD_SZ_W] <= wdata[AWD_EXT_W-1:0];
      end
    end

    assign rd_vec[w] =
        (sel_c ? {cfg_q.szm, cfg_q.attr, cfg_q.tgt, 3'b000, cfg_q.en} : 32'h0) |
        (sel_b ? {cfg_q.base[AWD_SZ_W-1:0], 12'h0, cfg_q.base[AWD_HI_W-1:AWD_SZ_W]} : 32'h0) |
        (sel_l ? {cfg_q.remap[AWD_SZ_W-1:0], 16'h0} : 32'h0) |
        (sel_h ? {28'h0, cfg_q.remap[AWD_HI_W-1:AWD_SZ_W]} : 32'h0);

    assign win[w] = cfg_q;
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WIN; w++) rd_mux = rd_mux | rd_vec[w];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= REG_AW'(AWD_HOLE_LO) && addr <= REG_AW'(AWD_HOLE_HI)) |=> (rdata == 32'h0)); // R5
endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 4
) (
  input  awd_win_t [NUM_WIN-1:0]                 win,
  input  logic [AWD_ADDR_W-1:0]                  lk_addr,
  output logic [NUM_WIN-1:0]                     hit_vec,
  output logic [NUM_WIN-1:0][AWD_ADDR_W-1:0]     xlat
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    localparam bit HAS_RMP = (w < NUM_REMAP);
    logic [AWD_HI_W-1:0] keep_m;
    logic [AWD_HI_W-1:0] hi_rmp;

    assign keep_m  = {{(AWD_HI_W-AWD_SZ_W){1'b0}}, win[w].szm};
    assign hit_vec[w] = win[w].en &&
        (((lk_addr[AWD_ADDR_W-1:AWD_PG_BITS] ^ win[w].base) & ~keep_m) == '0);
    assign hi_rmp  = (win[w].remap & ~keep_m) |
                     (lk_addr[AWD_ADDR_W-1:AWD_PG_BITS] & keep_m);
    assign xlat[w] = HAS_RMP ? {hi_rmp, lk_addr[AWD_PG_BITS-1:0]} : lk_addr;
  end
endmodule

// File: rtl/awd_select.sv
module awd_select
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               lk_valid,
  input  logic [AWD_ADDR_W-1:0]              lk_addr,
  input  logic [NUM_WIN-1:0]                 hit_vec,
  input  logic [NUM_WIN-1:0][AWD_ADDR_W-1:0] xlat,
  input  logic [NUM_WIN-1:0][3:0]            tgt_vec,
  input  logic [NUM_WIN-1:0][7:0]            attr_vec,
  output logic                               out_valid,
  output logic                               out_hit,
  output logic [3:0]                         out_tgt,
  output logic [7:0]                         out_attr,
  output logic [AWD_ADDR_W-1:0]              out_addr
);
  logic [NUM_WIN-1:0]    grant;
  logic                  found;
  logic [3:0]            sel_tgt;
  logic [7:0]            sel_attr;
  logic [AWD_ADDR_W-1:0] sel_xlat;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    sel_tgt  = '0;
    sel_attr = '0;
    sel_xlat = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      sel_tgt  = sel_tgt  | (tgt_vec[i]  & {4{grant[i]}});
      sel_attr = sel_attr | (attr_vec[i] & {8{grant[i]}});
      sel_xlat = sel_xlat | (xlat[i]     & {AWD_ADDR_W{grant[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_tgt   <= '0;
      out_attr  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= found;
      out_tgt   <= sel_tgt;
      out_attr  <= sel_attr;
      out_addr  <= found ? sel_xlat : lk_addr;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid); // R11
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_tgt == 4'h0 && out_attr == 8'h0)); // R9
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_addr == $past(lk_addr))); // R9
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr[AWD_PG_BITS-1:0] == $past(lk_addr[AWD_PG_BITS-1:0]))); // R6
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 4,
  parameter int REG_AW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  lk_valid,
  input  logic [35:0]           lk_addr,
  output logic                  lk_out_valid,
  output logic                  lk_hit,
  output logic [3:0]            lk_target,
  output logic [7:0]            lk_attr,
  output logic [35:0]           lk_out_addr
);
  awd_win_t [NUM_WIN-1:0]                 win;
  logic [NUM_WIN-1:0]                     hit_vec;
  logic [NUM_WIN-1:0][AWD_ADDR_W-1:0]     xlat;
  logic [NUM_WIN-1:0][3:0]                tgt_vec;
  logic [NUM_WIN-1:0][7:0]                attr_vec;

  awd_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .win(win)
  );

  awd_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .win(win), .lk_addr(lk_addr), .hit_vec(hit_vec), .xlat(xlat)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_fields
    assign tgt_vec[w]  = win[w].tgt;
    assign attr_vec[w] = win[w].attr;
  end

  awd_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .hit_vec(hit_vec), .xlat(xlat), .tgt_vec(tgt_vec), .attr_vec(attr_vec),
    .out_valid(lk_out_valid), .out_hit(lk_hit), .out_tgt(lk_target),
    .out_attr(lk_attr), .out_addr(lk_out_addr)
  );

  AST_HIT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(|hit_vec)); // R4
endmodule

// File: tb/tb_addr_window_decoder.sv
module tb_addr_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 20;
  localparam int NR = 4;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [35:0] lk_addr = '0;
  logic        lk_out_valid, lk_hit;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [35:0] lk_out_addr;

  addr_window_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR), .REG_AW(8)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_out_valid(lk_out_valid), .lk_hit(lk_hit), .lk_target(lk_target),
    .lk_attr(lk_attr), .lk_out_addr(lk_out_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];

  logic        e_valid, e_hit;
  logic [3:0]  e_tgt;
  logic [7:0]  e_attr;
  logic [35:0] e_addr;
  logic [31:0] e_rdata;

  function automatic int offs(input int n);
    if (n < 8) return n * 16;
    return 144 + (n - 8) * 8;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v = 32'h0;
    for (int w = 0; w < NW; w++) begin
      if (int'(a) == offs(w))     v = m_ctrl[w];
      if (int'(a) == offs(w) + 4) v = m_base[w];
      if (w < NR && int'(a) == offs(w) + 8)  v = m_rlo[w];
      if (w < NR && int'(a) == offs(w) + 12) v = m_rhi[w];
    end
    return v;
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [31:0] d);
    for (int w = 0; w < NW; w++) begin
      if (int'(a) == offs(w))     m_ctrl[w] = d & 32'hFFFF_FFF1;
      if (int'(a) == offs(w) + 4) m_base[w] = d & 32'hFFFF_000F;
      if (w < NR && int'(a) == offs(w) + 8)  m_rlo[w] = d & 32'hFFFF_0000;
      if (w < NR && int'(a) == offs(w) + 12) m_rhi[w] = d & 32'h0000_000F;
    end
  endtask

  task automatic m_lookup(input logic [35:0] a, output logic h, output logic [3:0] t,
                          output logic [7:0] at, output logic [35:0] o);
    h = 1'b0; t = '0; at = '0; o = a;
    for (int w = 0; w < NW; w++) begin
      logic [35:0] span, b36, r36;
      span = {4'h0, m_ctrl[w][31:16], 16'hFFFF};
      b36  = {m_base[w][3:0], m_base[w][31:16], 16'h0};
      r36  = {m_rhi[w][3:0], m_rlo[w][31:16], 16'h0};
      if (!h && m_ctrl[w][0] && ((a & ~span) == (b36 & ~span))) begin
        h  = 1'b1;
        t  = m_ctrl[w][7:4];
        at = m_ctrl[w][15:8];
        o  = (w < NR) ? ((r36 & ~span) | (a & span)) : a;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "lk_out_valid", 64'(lk_out_valid), 64'(e_valid));
    chk(tag, "lk_hit",       64'(lk_hit),       64'(e_hit));
    chk(tag, "lk_target",    64'(lk_target),    64'(e_tgt));
    chk(tag, "lk_attr",      64'(lk_attr),      64'(e_attr));
    chk(tag, "lk_out_addr",  64'(lk_out_addr),  64'(e_addr));
    chk(tag, "reg_rdata",    64'(reg_rdata),    64'(e_rdata));
  endtask

  task automatic tick(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] wd,
                      input logic lv, input logic [35:0] la, input string tag);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    lk_valid = lv; lk_addr = la;
    e_valid = lv;
    m_lookup(la, e_hit, e_tgt, e_attr, e_addr);
    if (rd) e_rdata = m_read(a);
    if (wr) m_write(a, wd);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
    tick(1'b1, 1'b0, a, d, 1'b0, 36'h0, tag);
  endtask
  task automatic rd_reg(input logic [7:0] a, input string tag);
    tick(1'b0, 1'b1, a, 32'h0, 1'b0, 36'h0, tag);
  endtask
  task automatic look(input logic [35:0] la, input string tag);
    tick(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, la, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
    end
    e_valid = 0; e_hit = 0; e_tgt = '0; e_attr = '0; e_addr = '0; e_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare_all("R1");

    // R1: everything reads zero and lookups miss after reset
    rd_reg(8'h00, "R1");
    rd_reg(8'h98, "R1");
    look(36'h0_0000_0000, "R1");
    look(36'h0_1234_5678, "R9");

    // Window 0: 1 MB at 0x0_1230_0000, remapped to 0x3_4560_0000
    wr_reg(8'h00, 32'h000F_E041, "R2");
    wr_reg(8'h04, 32'h1230_0000, "R3");
    wr_reg(8'h08, 32'h4560_0000, "R6");
    wr_reg(8'h0C, 32'h0000_0003, "R6");
    look(36'h0_1234_5678, "R6");
    look(36'h0_122F_FFFF, "R4");
    look(36'h0_1230_0000, "R4");
    look(36'h0_123F_FFFF, "R4");
    look(36'h0_1240_0000, "R4");
    // R2: bits 3:1 of control are not stored
    wr_reg(8'h00, 32'h000F_E04F, "R2");
    rd_reg(8'h00, "R2");
    rd_reg(8'h0C, "R5");

    // Window 5: no remap, 128 KB
    wr_reg(8'h50, 32'h0001_2D31, "R7");
    wr_reg(8'h54, 32'h8000_0000, "R7");
    wr_reg(8'h58, 32'hDEAD_0000, "R7");
    rd_reg(8'h58, "R7");
    wr_reg(8'h5C, 32'h0000_000F, "R7");
    rd_reg(8'h5C, "R7");
    look(36'h0_8001_2345, "R7");
    look(36'h0_8002_0000, "R4");

    // Window 10 (packed layout): 4 GB with high base bits
    wr_reg(8'hA0, 32'hFFFF_0181, "R5");
    wr_reg(8'hA4, 32'h1234_FFF5, "R3");
    rd_reg(8'hA4, "R3");
    rd_reg(8'hA0, "R5");
    look(36'h5_ABCD_0123, "R3");
    look(36'h4_FFFF_FFFF, "R4");

    // Overlap: window 9 inside window 0 region
    wr_reg(8'h98, 32'h0000_7791, "R8");
    wr_reg(8'h9C, 32'h1230_0000, "R8");
    look(36'h0_1230_0010, "R8");
    wr_reg(8'h00, 32'h0000_0000, "R10");
    look(36'h0_1230_0010, "R10");
    look(36'h0_1234_5678, "R10");

    // Reserved gap
    for (int k = 0; k < 4; k++) wr_reg(8'(8'h80 + k * 4), 32'hFFFF_FFFF, "R5");
    for (int k = 0; k < 4; k++) rd_reg(8'(8'h80 + k * 4), "R5");
    rd_reg(8'h9C, "R5");
    rd_reg(8'h08, "R5");

    // R11: write and lookup in one cycle, lookup sees the old state
    tick(1'b1, 1'b0, 8'h00, 32'h000F_E041, 1'b1, 36'h0_1234_5678, "R11");
    look(36'h0_1234_5678, "R11");
    tick(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 36'h0_1234_5678, "R11");
    tick(1'b0, 1'b1, 8'h08, 32'h0, 1'b1, 36'h0_1230_0001, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule